// File: doc/BRIEF.md
# Dual-Mode Interrupt Status Controller

This block gathers single-cycle event pulses from two DMA channels, an error group and a set of counter-related sources into a 64-bit sticky status register. A 64-bit mask register decides which latched bits may raise an interrupt. The top bit of the mask register is not a mask bit. It selects the signalling scheme. With that bit clear, one interrupt output covers every masked status bit. With it set, channel 1 events move to a second interrupt output, and each output gets its own clearing read.

Software reaches the block through a plain register port with one address for each of four registers:

| Address | Register | Access |
|---|---|---|
| 0 | Clearing status read | read |
| 1 | Channel-1 clearing status read | read |
| 2 | Debug status read, no side effects | read |
| 3 | Mask register | read/write |

Reads are combinational, so the data appears in the same cycle as the read strobe. Any clear takes effect at the next clock edge. Both interrupt outputs are registered level signals.

Top module: `irq_status_ctrl`

## Requirements
- R1: A high event input sets its status bit at the next clock edge. The bit stays set until a clearing read that covers it. Status bit 63 is reserved and always reads 0.
- R2: A status bit can raise an interrupt only while its mask bit is also set. Mask bit 63 is the mode select and never acts as a mask.
- R3: After reset, the status register, the mask register (including the mode bit) and both interrupt outputs are all 0. A mode bit of 0 means single-interrupt mode.
- R4: In single-interrupt mode, `irq_main_o` is the OR of all masked status bits 62:0, registered one cycle after the status. `irq_ch1_o` is held at 0.
- R5: In single-interrupt mode, a read of address 0 clears every status bit at the next edge.
- R6: In split mode, `irq_main_o` follows the masked channel 0 bits (23:16 and 7:0) and the masked error bits (46:40), one cycle after the status.
- R7: In split mode, `irq_ch1_o` follows the masked channel 1 bits (31:24 and 15:8), one cycle after the status.
- R8: In split mode, a read of address 0 clears only the channel 0 and error bits. A read of address 1 clears only the channel 1 bits. Counter bits (39:32 and 62:47) are not cleared by either read.
- R9: A read of address 2 returns the status and clears nothing.
- R10: In single-interrupt mode, a read of address 1 returns the status and clears nothing.
- R11: An event that arrives in the same cycle as a clearing read of its bit leaves the bit set. The read data for that cycle shows the value from before the clear.
- R12: While the read strobe is high, `reg_rdata` returns the status for addresses 0 to 2 and the mask register for address 3, in the same cycle. While the strobe is low, `reg_rdata` is 0. A write to address 3 replaces the mask register at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | 64 | Event pulses, one per status bit |
| reg_rd_en | input | 1 | Read strobe |
| reg_wr_en | input | 1 | Write strobe |
| reg_addr | input | 2 | Register address: 0 clearing read, 1 channel-1 clearing read, 2 debug read, 3 mask |
| reg_wdata | input | 64 | Write data for the mask register |
| reg_rdata | output | 64 | Combinational read data |
| irq_main_o | output | 1 | Main interrupt level |
| irq_ch1_o | output | 1 | Channel 1 interrupt level, used in split mode only |

## Verification
Directed sequences set one bit in each group in turn: channel 0, channel 1, error, counter and the reserved bit. Each sequence is run under both modes, and the bench watches which interrupt output rises and which bits survive each of the three read addresses. These runs separate the two clear partitions from each other and from the side-effect-free debug read. Masks that hold only one bit, combined with events on other bits, show whether gating works bit by bit or by group. An event placed in the same cycle as a clearing read shows whether the set has priority over the clear. A long pseudo-random phase mixes sparse events, reads at every address, mask rewrites and mode flips, and compares every cycle against the reference model.

// File: rtl/isc_pkg.sv
// isc_pkg: widths, register addresses and bit partitions shared by the
// interrupt status controller. Assumes a 64-bit status word in which the
// group positions are fixed, because software decodes them.
package isc_pkg;
    localparam int STAT_W   = 64;
    localparam int ADDR_W   = 2;
    localparam int MODE_BIT = STAT_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_STAT  = 2'd0,
        ADDR_STAT1 = 2'd1,
        ADDR_DBG   = 2'd2,
        ADDR_MASK  = 2'd3
    } reg_addr_e;

    // Build a vector with bits hi..lo set.
    function automatic logic [STAT_W-1:0] span(input int hi, input int lo);
        logic [STAT_W-1:0] v;
        v = '0;
        for (int i = lo; i <= hi; i++) v[i] = 1'b1;
        return v;
    endfunction

    localparam logic [STAT_W-1:0] GRP_CH0  = span(23, 16) | span(7, 0);
    localparam logic [STAT_W-1:0] GRP_CH1  = span(31, 24) | span(15, 8);
    localparam logic [STAT_W-1:0] GRP_ERR  = span(46, 40);
    localparam logic [STAT_W-1:0] GRP_ALL  = span(MODE_BIT - 1, 0);
    localparam logic [STAT_W-1:0] GRP_MAIN = GRP_CH0 | GRP_ERR;
endpackage

// File: rtl/isc_status_bank.sv
// isc_status_bank: a row of sticky status flops. Each bit is set by its event
// pulse and cleared by its clear strobe. The set wins if both are high in the
// same cycle. Assumes the events are single-cycle pulses in the clk domain.
// The bit at RSVD_BIT is reserved and is tied to 0.
module isc_status_bank #(
    parameter int W        = isc_pkg::STAT_W,
    parameter int RSVD_BIT = isc_pkg::MODE_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b == RSVD_BIT) begin : g_rsvd
            // Reserved position: constant zero, its event and clear are dropped.
            logic unused_in;
            assign unused_in   = ev_i[b] ^ clr_i[b];
            assign status_o[b] = 1'b0;
        end else begin : g_flop
            logic bit_q;
            // Sticky bit: a set has priority over a clear in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (ev_i[b])
                    bit_q <= 1'b1;
                else if (clr_i[b])
                    bit_q <= 1'b0;
            end
            assign status_o[b] = bit_q;
        end
    end
endmodule

// File: rtl/isc_regport.sv
// isc_regport: register access port. It holds the mask register (its top
// bit is the split-mode select), returns read data combinationally and
// decodes the clear vector for a clearing read. Assumes at most one access
// per cycle. A read takes priority if both strobes are high.
module isc_regport
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic [STAT_W-1:0] status_i,
    output logic [STAT_W-1:0] mask_o,
    output logic              split_o,
    output logic [STAT_W-1:0] clr_o,
    output logic [STAT_W-1:0] rdata_o
);
    reg_addr_e         addr;
    logic [STAT_W-1:0] mask_q;
    logic              wr_mask;

    assign addr    = reg_addr_e'(addr_i);
    assign wr_mask = wr_en_i && !rd_en_i && (addr == ADDR_MASK);

    // Mask register, including the mode select in its top bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_mask)
            mask_q <= wdata_i;
    end

    assign mask_o  = mask_q;
    assign split_o = mask_q[MODE_BIT];

    // Read data mux: status for the three status views, else the mask.
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (addr)
                ADDR_STAT, ADDR_STAT1, ADDR_DBG: rdata_o = status_i;
                ADDR_MASK:                       rdata_o = mask_q;
                default:                         rdata_o = '0;
            endcase
        end
    end

    // Clear decode: which latched bits a read of this address wipes.
    always_comb begin
        clr_o = '0;
        if (rd_en_i) begin
            unique case (addr)
                ADDR_STAT:  clr_o = split_o ? GRP_MAIN : GRP_ALL;
                ADDR_STAT1: clr_o = split_o ? GRP_CH1 : '0;
                default:    clr_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/isc_irq_gen.sv
// isc_irq_gen: combines status with mask and mode into two registered level
// interrupts. Assumes the status and mask arrive from flops, so each output
// follows the status with one cycle of latency.
module isc_irq_gen
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] status_i,
    input  logic [STAT_W-1:0] mask_i,
    input  logic              split_i,
    output logic              irq_main_o,
    output logic              irq_ch1_o
);
    logic [STAT_W-1:0] live;
    logic              any_all, any_main, any_ch1;
    logic              main_d, ch1_d;
    logic              main_q, ch1_q;

    // Masked status, restricted to the defined bits.
    assign live     = status_i & mask_i & GRP_ALL;
    assign any_all  = |live;
    assign any_main = |(live & GRP_MAIN);
    assign any_ch1  = |(live & GRP_CH1);

    // Mode steering: the single scheme folds every group onto the main line.
    always_comb begin
        if (split_i) begin
            main_d = any_main;
            ch1_d  = any_ch1;
        end else begin
            main_d = any_all;
            ch1_d  = 1'b0;
        end
    end

    // Output registers: glitch-free level interrupts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= 1'b0;
            ch1_q  <= 1'b0;
        end else begin
            main_q <= main_d;
            ch1_q  <= ch1_d;
        end
    end

    assign irq_main_o = main_q;
    assign irq_ch1_o  = ch1_q;
endmodule

// File: rtl/irq_status_ctrl.sv
// irq_status_ctrl: sticky interrupt status with a mask and a choice of one
// shared interrupt or split interrupts. The split scheme gives channel 1 its
// own interrupt and its own clearing read. Assumes synchronous, single-cycle
// event pulses and one register access per cycle.
module irq_status_ctrl
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev_i,
    input  logic              reg_rd_en,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic              irq_main_o,
    output logic              irq_ch1_o
);
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] clr_vec;
    logic              split_q;

    isc_status_bank #(.W(STAT_W), .RSVD_BIT(MODE_BIT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev_i),
        .clr_i    (clr_vec),
        .status_o (status_q)
    );

    isc_regport u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (reg_rd_en),
        .wr_en_i  (reg_wr_en),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .status_i (status_q),
        .mask_o   (mask_q),
        .split_o  (split_q),
        .clr_o    (clr_vec),
        .rdata_o  (reg_rdata)
    );

    isc_irq_gen u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_i   (status_q),
        .mask_i     (mask_q),
        .split_i    (split_q),
        .irq_main_o (irq_main_o),
        .irq_ch1_o  (irq_ch1_o)
    );
endmodule

// File: rtl/isc_checker.sv
// isc_checker: temporal properties of the interrupt status controller,
// bound to every instance of the top module.
module isc_checker
    import isc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] ev_i,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [STAT_W-1:0] status_q,
    input logic [STAT_W-1:0] mask_q,
    input logic              irq_main,
    input logic              irq_ch1
);
    // R1: the reserved status bit never sets.
    a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !status_q[MODE_BIT]);

    // R1: with no read in the previous cycle, no set bit was lost.
    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(rd_en) |->
            ((status_q & $past(status_q)) == $past(status_q)));

    // R2: the main interrupt needs a set bit that was also masked.
    a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_main |-> $past(|(status_q & mask_q)));

    // R4: the channel 1 line stays low when the previous cycle was in single mode.
    a_r4_ch1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mask_q[MODE_BIT]) |-> !irq_ch1);

    // R7: the channel 1 line needs a masked channel 1 bit in split mode.
    a_r7_ch1_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ch1 |-> $past(mask_q[MODE_BIT] && |(status_q & mask_q & GRP_CH1)));

    // R9: a debug read clears nothing.
    a_r9_debug_keep: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_en) && $past(addr) == ADDR_DBG |->
            ((status_q & $past(status_q)) == $past(status_q)));

    // R11: every event of the previous cycle is visible, clear or not.
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_q & $past(ev_i) & GRP_ALL) == ($past(ev_i) & GRP_ALL)));
endmodule

bind irq_status_ctrl isc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev_i),
    .rd_en    (reg_rd_en),
    .addr     (reg_addr),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_main (irq_main_o),
    .irq_ch1  (irq_ch1_o)
);

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
// tb_irq_status_ctrl: behavioural reference model compared on every clock.
module tb_irq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ev_i = '0;
    logic        reg_rd_en = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq_main_o, irq_ch1_o;

    int vectors = 0;
    int fails = 0;

    // Reference state.
    logic [63:0] m_stat = '0;
    logic [63:0] m_mask = '0;
    logic        m_main = 1'b0;
    logic        m_ch1 = 1'b0;

    always #4 clk = ~clk;

    irq_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .reg_rd_en(reg_rd_en),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_main_o(irq_main_o), .irq_ch1_o(irq_ch1_o)
    );

    function automatic bit in_ch0(int i);
        return (i <= 7) || (i >= 16 && i <= 23);
    endfunction
    function automatic bit in_ch1(int i);
        return (i >= 8 && i <= 15) || (i >= 24 && i <= 31);
    endfunction
    function automatic bit in_err(int i);
        return (i >= 40 && i <= 46);
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic cyc(logic [63:0] ev, logic rd, logic wr, logic [1:0] a,
                       logic [63:0] wd, string tag);
        logic [63:0] exp_rd, clr, nstat;
        logic        nmain, nch1, split;
        @(negedge clk);
        ev_i = ev; reg_rd_en = rd; reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
        #1;
        exp_rd = !rd ? 64'd0 : (a == 2'd3 ? m_mask : m_stat);
        check(tag, "rdata", reg_rdata, exp_rd);
        check(tag, "irq_main", {63'd0, irq_main_o}, {63'd0, m_main});
        check(tag, "irq_ch1", {63'd0, irq_ch1_o}, {63'd0, m_ch1});
        @(posedge clk);
        split = m_mask[63];
        nmain = 1'b0; nch1 = 1'b0; clr = '0;
        for (int i = 0; i < 64; i++) begin
            if (m_stat[i] && m_mask[i]) begin
                if (!split) nmain = 1'b1;
                else if (in_ch0(i) || in_err(i)) nmain = 1'b1;
                else if (in_ch1(i)) nch1 = 1'b1;
            end
            if (rd && a == 2'd0 && (!split || in_ch0(i) || in_err(i))) clr[i] = 1'b1;
            if (rd && a == 2'd1 && split && in_ch1(i)) clr[i] = 1'b1;
        end
        nstat = (m_stat & ~clr) | ev;
        nstat[63] = 1'b0;
        m_stat = nstat;
        m_main = nmain;
        m_ch1 = nch1;
        if (wr && !rd && a == 2'd3) m_mask = wd;
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) cyc('0, 1'b0, 1'b0, 2'd0, '0, tag);
    endtask

    task automatic rd(logic [1:0] a, string tag);
        cyc('0, 1'b1, 1'b0, a, '0, tag);
    endtask

    task automatic wmask(logic [63:0] v, string tag);
        cyc('0, 1'b0, 1'b1, 2'd3, v, tag);
    endtask

    task automatic fire(int b, string tag);
        logic [63:0] e;
        e = '0; e[b] = 1'b1;
        cyc(e, 1'b0, 1'b0, 2'd0, '0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [63:0] s1, s2, s3;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R3: reset values of mask, status and both lines.
        rd(2'd3, "R3");
        rd(2'd2, "R3");
        // R4, R1: single mode, event on bit 5 raises main only, and it stays.
        wmask({1'b0, {63{1'b1}}}, "R4");
        fire(5, "R1");
        idle(3, "R4");
        fire(63, "R1");
        fire(9, "R4");
        idle(2, "R1");
        rd(2'd2, "R9");
        rd(2'd2, "R9");
        rd(2'd1, "R10");
        rd(2'd1, "R10");
        fire(44, "R4");
        rd(2'd0, "R5");
        idle(3, "R5");
        // R2: a mask with only bit 40 does not pass an event on bit 3.
        wmask(64'h0000_0100_0000_0000, "R2");
        fire(3, "R2");
        idle(3, "R2");
        fire(40, "R2");
        idle(3, "R2");
        rd(2'd0, "R5");
        idle(2, "R2");
        // R6, R7, R8: split mode with the full mask.
        wmask('1, "R6");
        fire(9, "R7");
        idle(3, "R7");
        fire(0, "R6");
        fire(44, "R6");
        fire(35, "R8");
        idle(3, "R6");
        rd(2'd0, "R8");
        idle(3, "R8");
        rd(2'd2, "R8");
        rd(2'd1, "R8");
        idle(3, "R8");
        rd(2'd2, "R8");
        // R11: an event in the same cycle as the clear of its bit survives.
        fire(2, "R11");
        cyc(64'h4, 1'b1, 1'b0, 2'd0, '0, "R11");
        rd(2'd2, "R11");
        fire(26, "R11");
        cyc(64'h0400_0000, 1'b1, 1'b0, 2'd1, '0, "R11");
        rd(2'd2, "R11");
        // R12: read strobe gating and write ignored while reading.
        cyc('0, 1'b1, 1'b1, 2'd3, 64'h1234, "R12");
        rd(2'd3, "R12");
        wmask(64'h8000_0000_FF00_00FF, "R12");
        rd(2'd3, "R12");
        idle(2, "R12");
        // Mixed random traffic with mode flips.
        s1 = 64'h9E37_79B9_7F4A_7C15;
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] ev;
            s1 ^= s1 << 13; s1 ^= s1 >> 7; s1 ^= s1 << 17;
            s2 = s1 ^ (s1 >> 11); s3 = s1 * 64'd2654435761;
            ev = s1 & s2 & s3 & (s3 >> 5);
            case (s1[58:56])
                3'd0, 3'd1: cyc(ev, 1'b1, 1'b0, 2'd0, '0, "R2");
                3'd2:       cyc(ev, 1'b1, 1'b0, 2'd1, '0, "R8");
                3'd3:       cyc(ev, 1'b1, 1'b0, 2'd2, '0, "R9");
                3'd4:       cyc(ev, 1'b0, (s1[20:16] == 5'd0), 2'd3, s2, "R12");
                default:    cyc(ev, 1'b0, 1'b0, s1[1:0], '0, "R1");
            endcase
        end
        idle(2, "R1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule